// File: doc/BRIEF.md
# Scaled Cycle-Count Timestamp

This unit turns a fast free-running cycle counter into a 64-bit time value counted in 100 ns ticks. Between coarse reference updates it interpolates: it remembers a snapshot pair (reference ticks, cycle count), measures how many cycles have passed since that snapshot, multiplies the distance by a fixed-point rate with 24 fraction bits, and adds the result to the snapshotted ticks. The rate is supplied from outside as 2^24 × 10,000,000 / cycle frequency, which keeps one tick at or above one cycle for any counter running at 10 MHz or faster.

A resync pulse, issued on each once-per-second reference step or after the counter has been halted and resumed, takes a fresh snapshot. The sample that takes the snapshot reports the reference value itself. A bypass input reports the reference directly without touching the snapshot. Interpolated results are clamped so that time never runs backwards, except when the value crosses from the positive half of the signed range into the negative half, which is treated as a wrap and let through.

Each sample goes through a three-stage pipeline. A valid flag travels with it and marks every cycle whose output holds a real result.

Top module: `tick_stamp`

## Requirements
- R1: While reset is asserted, `ts_o` is 0 and `vld_o` is 0.
- R2: An interpolated sample reports snapshot_ticks + ((cyc_i − snapshot_cycles) × scale_i) >> 24, where `scale_i` has 24 fraction bits (0x0100_0000 is one tick per cycle, 0x0280_0000 is 2.5 ticks per cycle) and the cycle distance is taken modulo 2^32.
- R3: A sample with `resync_i` high stores `ref_i` and `cyc_i` as the new snapshot and reports exactly `ref_i`, even when that is lower than the previous output.
- R4: The first sample after reset finds no valid snapshot and takes one automatically, as if `resync_i` were high.
- R5: An interpolated result that is lower than the previous output, compared as signed 64-bit values, is replaced by the previous output.
- R6: An interpolated result with bit 63 set that follows an output with bit 63 clear is reported unchanged, as a wrap.
- R7: A sample with `bypass_i` high reports `ref_i` unclamped and leaves the snapshot unchanged for later samples.
- R8: The result for inputs sampled at a rising edge appears on `ts_o` after the third rising edge. `vld_o` rises once the pipeline is full after reset and then stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_i | input | 64 | Free-running cycle count |
| ref_i | input | 64 | Coarse reference time in 100 ns ticks |
| resync_i | input | 1 | Take a new snapshot with this sample |
| bypass_i | input | 1 | Report the reference directly for this sample |
| scale_i | input | 32 | Ticks per cycle, unsigned with 24 fraction bits |
| ts_o | output | 64 | Monotonic time in 100 ns ticks |
| vld_o | output | 1 | `ts_o` holds a pipeline result |

## Verification
Inputs sampled at one rising edge yield an output three rising edges later. The bench therefore drives each vector on a falling edge and compares `ts_o` on the falling edge three cycles after that. Because the internal reset release adds a few cycles of its own, the bench does not count cycles from reset. It holds the first vector steady and waits for `vld_o` to rise, which gives it a fixed starting point. From there it applies one vector per cycle and checks each result exactly three falling edges after the vector was driven. The wrap and clamp corner cases use the same three-cycle offset.

// File: rtl/tick_stamp_pkg.sv
package tick_stamp_pkg;
  // How the sample in flight is to be treated by the clamp stage
  typedef enum logic [1:0] {
    SMP_INTERP  = 2'd0,
    SMP_CAPTURE = 2'd1,
    SMP_BYPASS  = 2'd2
  } smp_kind_e;
endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/ts_snap.sv
module ts_snap
  import tick_stamp_pkg::*;
#(
  parameter int CYC_W   = 64,
  parameter int TS_W    = 64,
  parameter int DELTA_W = 32,
  parameter int SCALE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CYC_W-1:0]   cyc_i,
  input  logic [TS_W-1:0]    ref_i,
  input  logic               resync_i,
  input  logic               bypass_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               vld_o,
  output smp_kind_e          kind_o,
  output logic [TS_W-1:0]    base_o,
  output logic [DELTA_W-1:0] delta_o,
  output logic [SCALE_W-1:0] scale_o
);
  // snapshot state
  logic               snap_vld_q;
  logic [CYC_W-1:0]   snap_cyc_q;
  logic [TS_W-1:0]    snap_tk_q;
  logic               snap_en;
  // stage registers
  logic               vld_q;
  smp_kind_e          kind_q, kind_d;
  logic [TS_W-1:0]    base_q, base_d;
  logic [DELTA_W-1:0] delta_q, delta_d;
  logic [SCALE_W-1:0] scale_q;
  logic               direct;

  always_comb begin
    snap_en = resync_i | ~snap_vld_q;
    direct  = snap_en | bypass_i;
    if (bypass_i)     kind_d = SMP_BYPASS;
    else if (snap_en) kind_d = SMP_CAPTURE;
    else              kind_d = SMP_INTERP;
    base_d  = direct ? ref_i : snap_tk_q;
    delta_d = direct ? '0 : DELTA_W'(cyc_i - snap_cyc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_vld_q <= 1'b0;
      snap_cyc_q <= '0;
      snap_tk_q  <= '0;
    end else if (snap_en) begin
      snap_vld_q <= 1'b1;
      snap_cyc_q <= cyc_i;
      snap_tk_q  <= ref_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      kind_q  <= SMP_INTERP;
      base_q  <= '0;
      delta_q <= '0;
      scale_q <= '0;
    end else begin
      vld_q   <= 1'b1;
      kind_q  <= kind_d;
      base_q  <= base_d;
      delta_q <= delta_d;
      scale_q <= scale_i;
    end
  end

  assign vld_o   = vld_q;
  assign kind_o  = kind_q;
  assign base_o  = base_q;
  assign delta_o = delta_q;
  assign scale_o = scale_q;
endmodule

// File: rtl/ts_mul.sv
module ts_mul
  import tick_stamp_pkg::*;
#(
  parameter int TS_W    = 64,
  parameter int DELTA_W = 32,
  parameter int SCALE_W = 32,
  localparam int PROD_W = DELTA_W + SCALE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld_i,
  input  smp_kind_e          kind_i,
  input  logic [TS_W-1:0]    base_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               vld_o,
  output smp_kind_e          kind_o,
  output logic [TS_W-1:0]    base_o,
  output logic [PROD_W-1:0]  prod_o
);
  logic [PROD_W-1:0] prod_d;

  always_comb begin
    prod_d = PROD_W'(delta_i) * PROD_W'(scale_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      kind_o <= SMP_INTERP;
      base_o <= '0;
      prod_o <= '0;
    end else begin
      vld_o  <= vld_i;
      kind_o <= kind_i;
      base_o <= base_i;
      prod_o <= prod_d;
    end
  end
endmodule

// File: rtl/ts_clamp.sv
module ts_clamp
  import tick_stamp_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int PROD_W = 64,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  smp_kind_e         kind_i,
  input  logic [TS_W-1:0]   base_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [TS_W-1:0]   ts_o,
  output logic              vld_o
);
  localparam int MSB = TS_W - 1;

  logic [TS_W-1:0] raw;
  logic [TS_W-1:0] ts_d;
  logic            behind;
  logic            wraps;
  logic            hold;

  always_comb begin
    raw    = base_i + TS_W'(prod_i >> FRAC_W);
    behind = $signed(raw) < $signed(ts_o);
    wraps  = raw[MSB] & ~ts_o[MSB];
    hold   = (kind_i == SMP_INTERP) & behind & ~wraps;
    ts_d   = hold ? ts_o : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_o  <= '0;
      vld_o <= 1'b0;
    end else if (vld_i) begin
      ts_o  <= ts_d;
      vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_stamp.sv
module tick_stamp
  import tick_stamp_pkg::*;
#(
  parameter int CYC_W       = 64,
  parameter int TS_W        = 64,
  parameter int DELTA_W     = 32,
  parameter int SCALE_W     = 32,
  parameter int FRAC_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CYC_W-1:0]   cyc_i,
  input  logic [TS_W-1:0]    ref_i,
  input  logic               resync_i,
  input  logic               bypass_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [TS_W-1:0]    ts_o,
  output logic               vld_o
);
  localparam int PROD_W = DELTA_W + SCALE_W;

  logic               rst_n_int;
  logic               s1_vld;
  smp_kind_e          s1_kind;
  logic [TS_W-1:0]    s1_base;
  logic [DELTA_W-1:0] s1_delta;
  logic [SCALE_W-1:0] s1_scale;
  logic               s2_vld;
  smp_kind_e          s2_kind;
  logic [TS_W-1:0]    s2_base;
  logic [PROD_W-1:0]  s2_prod;

  ts_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  ts_snap #(.CYC_W(CYC_W), .TS_W(TS_W), .DELTA_W(DELTA_W), .SCALE_W(SCALE_W)) u_snap (
    .clk(clk), .rst_n(rst_n_int), .cyc_i(cyc_i), .ref_i(ref_i),
    .resync_i(resync_i), .bypass_i(bypass_i), .scale_i(scale_i),
    .vld_o(s1_vld), .kind_o(s1_kind), .base_o(s1_base),
    .delta_o(s1_delta), .scale_o(s1_scale)
  );

  ts_mul #(.TS_W(TS_W), .DELTA_W(DELTA_W), .SCALE_W(SCALE_W)) u_mul (
    .clk(clk), .rst_n(rst_n_int), .vld_i(s1_vld), .kind_i(s1_kind),
    .base_i(s1_base), .delta_i(s1_delta), .scale_i(s1_scale),
    .vld_o(s2_vld), .kind_o(s2_kind), .base_o(s2_base), .prod_o(s2_prod)
  );

  ts_clamp #(.TS_W(TS_W), .PROD_W(PROD_W), .FRAC_W(FRAC_W)) u_clamp (
    .clk(clk), .rst_n(rst_n_int), .vld_i(s2_vld), .kind_i(s2_kind),
    .base_i(s2_base), .prod_i(s2_prod), .ts_o(ts_o), .vld_o(vld_o)
  );
endmodule

// File: rtl/tick_stamp_chk.sv
module tick_stamp_chk
  import tick_stamp_pkg::*;
#(
  parameter int TS_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            resync_i,
  input logic            bypass_i,
  input logic [TS_W-1:0] ref_i,
  input logic [TS_W-1:0] ts_o,
  input logic            vld_o,
  input smp_kind_e       s2_kind
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !vld_o);

  // R8
  vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> vld_o);

  // R3
  direct_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && ($past(resync_i, 3) || $past(bypass_i, 3))) |-> ts_o == $past(ref_i, 3));

  // R5
  no_backstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(vld_o) && $past(s2_kind) == SMP_INTERP) |->
      ($signed(ts_o) >= $signed($past(ts_o)) || (ts_o[TS_W-1] && !$past(ts_o[TS_W-1]))));
endmodule

bind tick_stamp tick_stamp_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .resync_i(resync_i), .bypass_i(bypass_i),
  .ref_i(ref_i), .ts_o(ts_o), .vld_o(vld_o), .s2_kind(s2_kind)
);

// File: tb/sim_tick_stamp.sv
`timescale 1ns/1ps
module sim_tick_stamp;
  typedef struct packed {
    logic [63:0] cyc;
    logic [63:0] rfv;
    logic        rs;
    logic        by;
    logic [31:0] scl;
    logic [63:0] exp;
  } vec_t;

  localparam logic [31:0] ONE  = 32'h0100_0000;
  localparam logic [31:0] TWOH = 32'h0280_0000;
  localparam int NV = 11;
  // cyc, ref, resync, bypass, scale, expected
  localparam vec_t TBL [NV] = '{
    '{64'd100,  64'd5000, 1'b0, 1'b0, ONE,  64'd5000}, // R4 auto capture
    '{64'd110,  64'd5000, 1'b0, 1'b0, ONE,  64'd5010}, // R2
    '{64'd130,  64'd5000, 1'b0, 1'b0, TWOH, 64'd5075}, // R2
    '{64'd131,  64'd5000, 1'b0, 1'b0, TWOH, 64'd5077}, // R2 fraction dropped
    '{64'd200,  64'd6000, 1'b1, 1'b0, TWOH, 64'd6000}, // R3
    '{64'd204,  64'd6000, 1'b0, 1'b0, TWOH, 64'd6010}, // R2
    '{64'd210,  64'd5900, 1'b1, 1'b0, TWOH, 64'd5900}, // R3 backwards resync
    '{64'd210,  64'd5900, 1'b0, 1'b0, TWOH, 64'd5900}, // R2 zero distance
    '{64'd212,  64'd7777, 1'b0, 1'b1, TWOH, 64'd7777}, // R7 bypass
    '{64'd212,  64'd6100, 1'b0, 1'b0, TWOH, 64'd7777}, // R5 clamp
    '{64'd1000, 64'd6100, 1'b0, 1'b0, TWOH, 64'd7875}  // R7 snapshot kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cyc_i = '0;
  logic [63:0] ref_i = '0;
  logic        resync_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic [31:0] scale_i = '0;
  logic [63:0] ts_o;
  logic        vld_o;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  tick_stamp u0 (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .ref_i(ref_i),
    .resync_i(resync_i), .bypass_i(bypass_i), .scale_i(scale_i),
    .ts_o(ts_o), .vld_o(vld_o)
  );

  task automatic apply(input vec_t v);
    cyc_i = v.cyc; ref_i = v.rfv; resync_i = v.rs; bypass_i = v.by; scale_i = v.scl;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    apply(TBL[0]);
    repeat (3) @(negedge clk);
    chk("R1 ts in reset", ts_o, 64'd0);
    chk("R1 vld in reset", {63'd0, vld_o}, 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 20 && !vld_o; k++) @(negedge clk);
    chk("R8 vld rises", {63'd0, vld_o}, 64'd1);
    chk("R4 first sample", ts_o, TBL[0].exp);

    // table walk: vector j driven now, checked three falling edges later
    for (int j = 1; j < NV + 3; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        chk($sformatf("R2/R3/R5/R7 vector %0d", j - 3), ts_o, TBL[j-3].exp);
        chk("R8 vld held", {63'd0, vld_o}, 64'd1);
      end
      if (j < NV) apply(TBL[j]);
    end

    // wrap from positive to negative, then clamp inside the negative half
    @(negedge clk);
    apply('{64'd0, 64'h7FFF_FFFF_FFFF_FFF0, 1'b1, 1'b0, ONE, 64'd0});
    @(negedge clk);
    apply('{64'd100, 64'd0, 1'b0, 1'b0, ONE, 64'd0});
    @(negedge clk);
    apply('{64'd99, 64'd0, 1'b0, 1'b0, ONE, 64'd0});
    @(negedge clk);
    chk("R3 resync near top", ts_o, 64'h7FFF_FFFF_FFFF_FFF0);
    @(negedge clk);
    chk("R6 wrap passes", ts_o, 64'h8000_0000_0000_0054);
    @(negedge clk);
    chk("R5 clamp after wrap", ts_o, 64'h8000_0000_0000_0054);

    // reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ts after reset", ts_o, 64'd0);
    chk("R1 vld after reset", {63'd0, vld_o}, 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule